// File: doc/BRIEF.md
# Configuration Access Termination Handler

This block sits on the initiator side of a bridge between a processor local bus and a PCI-style bus. It takes one configuration read or write at a time from the local-bus master, launches an attempt on the PCI side, and reads the termination code that comes back. From that code it decides whether to launch the attempt again, what data to return, whether the access succeeded, and which sticky interrupt bit to raise.

Reads that are told to retry are relaunched with no limit. Writes that are told to retry are relaunched only up to a parameterised budget. System error, master abort and target abort all make a read return all ones. A data parity error still delivers read data, but it is flagged. The PCI side is modelled as a one-cycle start pulse followed later by a one-cycle response that carries a 3-bit termination code and read data.

Top module: `cfgx_term_handler`

## Requirements
- R1: A request is taken only while `req_ready` is high. `req_ready` is high only while no access is in flight. A `req_valid` pulse while busy is ignored and does not change the attempts or the completion of the access in flight.
- R2: Each attempt is a one-cycle `pci_start` pulse. During that pulse, `pci_write` and `pci_wdata` carry the accepted request.
- R3: Termination codes are: 0 normal, 1 disconnect with data, 2 retry, 3 master abort, 4 target abort, 5 system error, 6 parity error. Code 7 is handled as master abort. Codes 0 and 1 complete with `done_ok` high. A read returns `pci_rdata`; a write returns zero.
- R4: A read answered with code 2 is relaunched until some other code arrives.
- R5: A write answered with code 2 is relaunched at most `WR_RETRIES` times. If the last allowed attempt also gets code 2, the access ends with `done_ok` low and data all ones, and interrupt bit 5 (write retry) is set.
- R6: System error (5) on a read returns all ones and sets bit 0. On a write it sets bit 3. Both end with `done_ok` low.
- R7: Master abort (3) on a read returns all ones and sets no interrupt. On a write it sets bit 4. Both end with `done_ok` low.
- R8: Target abort (4) on a read returns all ones and sets bit 1. On a write it sets bit 6. Both end with `done_ok` low.
- R9: Parity error (6) on a read returns `pci_rdata` with `done_ok` high and sets bit 2. On a write it completes with `done_ok` high and sets bit 7.
- R10: `done` is a one-cycle pulse in the cycle after the final response. `done_ok` and `done_rdata` are valid with it. A failed access always carries all ones.
- R11: Interrupt bits in `irq_status` stay set until a 1 is written to the same bit of `irq_clear`. If a bit is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Configuration request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Handler idle, request may be taken |
| pci_start | output | 1 | One-cycle attempt launch |
| pci_write | output | 1 | Direction of the attempt |
| pci_wdata | output | DATA_W | Write data of the attempt |
| pci_resp_valid | input | 1 | Termination response strobe |
| pci_resp_code | input | 3 | Termination code |
| pci_rdata | input | DATA_W | Read data with the response |
| done | output | 1 | Completion pulse |
| done_ok | output | 1 | Access succeeded |
| done_rdata | output | DATA_W | Read data, zero for a good write, all ones on failure |
| irq_status | output | 8 | Sticky interrupt bits |
| irq_clear | input | 8 | Write-one-to-clear strobe |

## Verification
The bench goes after the split between reads and writes on a retry. A handler that bounds read retries would finish a long read chain early with the wrong data. One that is off by one on the write budget would show one attempt too many or too few before raising bit 5. Each error code is driven in both directions, so a crossed interrupt bit, a parity error that wrongly forces all ones, or a master abort on a read that raises an interrupt all show up at the ports. The bench also holds the clear strobe through a completing access, which catches a bank where clear beats set. It sends a request while the handler is busy, which catches a handler that restarts or adds an attempt.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int IRQ_W = 8;

    localparam int IRQ_RD_SERR   = 0;
    localparam int IRQ_RD_TABORT = 1;
    localparam int IRQ_RD_PERR   = 2;
    localparam int IRQ_WR_SERR   = 3;
    localparam int IRQ_WR_MABORT = 4;
    localparam int IRQ_WR_RETRY  = 5;
    localparam int IRQ_WR_TABORT = 6;
    localparam int IRQ_WR_PERR   = 7;

    typedef enum logic [2:0] {
        TERM_NORMAL    = 3'd0,
        TERM_DISC_DATA = 3'd1,
        TERM_RETRY     = 3'd2,
        TERM_MABORT    = 3'd3,
        TERM_TABORT    = 3'd4,
        TERM_SERR      = 3'd5,
        TERM_PERR      = 3'd6,
        TERM_RSVD      = 3'd7
    } term_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic             ok;
        logic             ones;
        logic [IRQ_W-1:0] irq;
    } outcome_t;

    // Result of a final termination; a retry reaching here is an exhausted write.
    function automatic outcome_t classify(term_e code, logic is_wr);
        outcome_t o;
        o.ok   = 1'b0;
        o.ones = 1'b1;
        o.irq  = '0;
        case (code)
            TERM_NORMAL, TERM_DISC_DATA: begin
                o.ok   = 1'b1;
                o.ones = 1'b0;
            end
            TERM_PERR: begin
                o.ok   = 1'b1;
                o.ones = 1'b0;
                o.irq[is_wr ? IRQ_WR_PERR : IRQ_RD_PERR] = 1'b1;
            end
            TERM_SERR:   o.irq[is_wr ? IRQ_WR_SERR : IRQ_RD_SERR] = 1'b1;
            TERM_TABORT: o.irq[is_wr ? IRQ_WR_TABORT : IRQ_RD_TABORT] = 1'b1;
            TERM_RETRY:  o.irq[IRQ_WR_RETRY] = is_wr;
            default:     o.irq[IRQ_WR_MABORT] = is_wr;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/cfgx_seq.sv
module cfgx_seq
    import cfgx_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int WR_RETRIES = 3,
    parameter int CNT_W      = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              pci_start,
    output logic              pci_write,
    output logic [DATA_W-1:0] pci_wdata,
    input  logic              resp_valid,
    input  logic [2:0]        resp_code,
    output logic              fin,
    output logic              fin_write
);

    seq_state_e        st;
    logic              wr_q;
    logic [DATA_W-1:0] wd_q;
    logic [CNT_W-1:0]  cnt;
    term_e             code;
    logic              budget_left;
    logic              reissue;
    logic              got_resp;

    assign code        = term_e'(resp_code);
    assign budget_left = (cnt < CNT_W'(WR_RETRIES));
    assign got_resp    = (st == SEQ_WAIT) && resp_valid;
    assign reissue     = got_resp && (code == TERM_RETRY) && (!wr_q || budget_left);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SEQ_IDLE;
            wr_q <= 1'b0;
            wd_q <= '0;
            cnt  <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (req_valid) begin
                        st   <= SEQ_ISSUE;
                        wr_q <= req_write;
                        wd_q <= req_wdata;
                        cnt  <= '0;
                    end
                end
                SEQ_ISSUE: st <= SEQ_WAIT;
                SEQ_WAIT: begin
                    if (reissue) begin
                        st <= SEQ_ISSUE;
                        if (wr_q) cnt <= cnt + 1'b1;
                    end else if (got_resp) begin
                        st <= SEQ_IDLE;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    assign req_ready = (st == SEQ_IDLE);
    assign pci_start = (st == SEQ_ISSUE);
    assign pci_write = wr_q;
    assign pci_wdata = wd_q;
    assign fin       = got_resp && !reissue;
    assign fin_write = wr_q;

endmodule

// File: rtl/cfgx_result.sv
module cfgx_result
    import cfgx_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fin,
    input  logic              fin_write,
    input  logic [2:0]        resp_code,
    input  logic [DATA_W-1:0] pci_rdata,
    output logic              done,
    output logic              done_ok,
    output logic [DATA_W-1:0] done_rdata,
    output logic [IRQ_W-1:0]  irq_set
);

    outcome_t          oc;
    logic [DATA_W-1:0] data_n;

    always_comb begin
        oc = classify(term_e'(resp_code), fin_write);
        if (oc.ones)
            data_n = '1;
        else if (fin_write)
            data_n = '0;
        else
            data_n = pci_rdata;
    end

    assign irq_set = fin ? oc.irq : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            done       <= 1'b0;
            done_ok    <= 1'b0;
            done_rdata <= '0;
        end else begin
            done <= fin;
            if (fin) begin
                done_ok    <= oc.ok;
                done_rdata <= data_n;
            end
        end
    end

endmodule

// File: rtl/cfgx_irq_bank.sv
module cfgx_irq_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] status
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                status[i] <= 1'b0;
            else if (set_i[i])
                status[i] <= 1'b1;
            else if (clr_i[i])
                status[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/cfgx_term_handler.sv
module cfgx_term_handler
    import cfgx_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int WR_RETRIES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              pci_start,
    output logic              pci_write,
    output logic [DATA_W-1:0] pci_wdata,
    input  logic              pci_resp_valid,
    input  logic [2:0]        pci_resp_code,
    input  logic [DATA_W-1:0] pci_rdata,
    output logic              done,
    output logic              done_ok,
    output logic [DATA_W-1:0] done_rdata,
    output logic [7:0]        irq_status,
    input  logic [7:0]        irq_clear
);

    localparam int CNT_W = $clog2(WR_RETRIES + 2);

    logic             fin;
    logic             fin_write;
    logic [IRQ_W-1:0] irq_set;

    cfgx_seq #(
        .DATA_W     (DATA_W),
        .WR_RETRIES (WR_RETRIES),
        .CNT_W      (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .req_ready  (req_ready),
        .pci_start  (pci_start),
        .pci_write  (pci_write),
        .pci_wdata  (pci_wdata),
        .resp_valid (pci_resp_valid),
        .resp_code  (pci_resp_code),
        .fin        (fin),
        .fin_write  (fin_write)
    );

    cfgx_result #(
        .DATA_W (DATA_W)
    ) res_i (
        .clk        (clk),
        .rst        (rst),
        .fin        (fin),
        .fin_write  (fin_write),
        .resp_code  (pci_resp_code),
        .pci_rdata  (pci_rdata),
        .done       (done),
        .done_ok    (done_ok),
        .done_rdata (done_rdata),
        .irq_set    (irq_set)
    );

    cfgx_irq_bank #(
        .W (IRQ_W)
    ) irq_i (
        .clk    (clk),
        .rst    (rst),
        .set_i  (irq_set),
        .clr_i  (irq_clear),
        .status (irq_status)
    );

endmodule

// File: rtl/cfgx_term_handler_chk.sv
module cfgx_term_handler_chk #(
    parameter int DATA_W     = 32,
    parameter int WR_RETRIES = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_write,
    input logic              req_ready,
    input logic              pci_start,
    input logic              done,
    input logic              done_ok,
    input logic [DATA_W-1:0] done_rdata,
    input logic [7:0]        irq_status,
    input logic [7:0]        irq_clear
);

    logic [15:0] att_cnt;
    logic        cur_wr;
    logic        past_ok;
    logic [7:0]  prev_irq;
    logic [7:0]  prev_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            att_cnt  <= '0;
            cur_wr   <= 1'b0;
            past_ok  <= 1'b0;
            prev_irq <= '0;
            prev_clr <= '0;
        end else begin
            past_ok  <= 1'b1;
            prev_irq <= irq_status;
            prev_clr <= irq_clear;
            if (req_valid && req_ready) begin
                att_cnt <= '0;
                cur_wr  <= req_write;
            end else if (pci_start && att_cnt != 16'hFFFF) begin
                att_cnt <= att_cnt + 16'd1;
            end
        end
    end

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        pci_start |-> !req_ready);                                   // R1

    AST_WR_ATTEMPT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (pci_start && cur_wr) |-> (att_cnt <= 16'(WR_RETRIES)));    // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                             // R10

    AST_FAIL_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
        (done && !done_ok) |-> (done_rdata == '1));                  // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((prev_irq & ~prev_clr & ~irq_status) == 8'h00)); // R11

    AST_READ_NO_WRITE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (past_ok && done && !cur_wr) |-> ((irq_status & ~prev_irq & 8'hF8) == 8'h00)); // R6

endmodule

bind cfgx_term_handler cfgx_term_handler_chk #(
    .DATA_W     (DATA_W),
    .WR_RETRIES (WR_RETRIES)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .pci_start  (pci_start),
    .done       (done),
    .done_ok    (done_ok),
    .done_rdata (done_rdata),
    .irq_status (irq_status),
    .irq_clear  (irq_clear)
);

// File: tb/cfgx_term_handler_tb_top.sv
module cfgx_term_handler_tb_top;

    localparam int DW  = 32;
    localparam int WRR = 3;
    localparam logic [31:0] ONES = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          pci_start;
    logic          pci_write;
    logic [DW-1:0] pci_wdata;
    logic          pci_resp_valid = 1'b0;
    logic [2:0]    pci_resp_code = 3'd0;
    logic [DW-1:0] pci_rdata = '0;
    logic          done;
    logic          done_ok;
    logic [DW-1:0] done_rdata;
    logic [7:0]    irq_status;
    logic [7:0]    irq_clear = '0;

    always #2.5 clk = ~clk;

    cfgx_term_handler #(.DATA_W(DW), .WR_RETRIES(WRR)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready),
        .pci_start(pci_start), .pci_write(pci_write), .pci_wdata(pci_wdata),
        .pci_resp_valid(pci_resp_valid), .pci_resp_code(pci_resp_code),
        .pci_rdata(pci_rdata),
        .done(done), .done_ok(done_ok), .done_rdata(done_rdata),
        .irq_status(irq_status), .irq_clear(irq_clear)
    );

    typedef struct {
        logic        ok;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [2:0]    term_q[$];
    int            checks = 0;
    int            errors = 0;
    int            start_cnt = 0;
    logic          last_wr = 1'b0;
    logic [31:0]   last_wd = '0;
    logic [31:0]   rsp_data = '0;
    logic          finished = 1'b0;

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // PCI-side responder: answers each start two cycles later
    initial begin
        forever begin
            @(negedge clk);
            while (pci_start) begin
                logic [2:0] c;
                start_cnt++;
                last_wr = pci_write;
                last_wd = pci_wdata;
                c = (term_q.size() > 0) ? term_q.pop_front() : 3'd0;
                @(negedge clk);
                @(negedge clk);
                pci_resp_valid = 1'b1;
                pci_resp_code  = c;
                pci_rdata      = rsp_data;
                @(negedge clk);
                pci_resp_valid = 1'b0;
            end
        end
    end

    // Monitor: compare each completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R1/R10 unexpected done", 64'(done), 64'd0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(done_ok == e.ok, {e.tag, " done_ok"}, 64'(done_ok), 64'(e.ok));
                    chk(done_rdata == e.data, {e.tag, " done_rdata"}, 64'(done_rdata), 64'(e.data));
                end
            end
        end
    end

    task automatic txn(input bit wr, input logic [31:0] wd, input logic [31:0] rd,
                       input bit exp_ok, input logic [31:0] exp_data,
                       input logic [7:0] exp_irq, input int exp_att,
                       input logic [7:0] clr_after, input bit hold_clr, input string tag);
        rsp_data  = rd;
        start_cnt = 0;
        sb_q.push_back('{exp_ok, exp_data, tag});
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        if (hold_clr) irq_clear = 8'hFF;
        req_valid = 1'b1;
        req_write = wr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        irq_clear = 8'h00;
        chk(start_cnt == exp_att, {tag, " attempts"}, 64'(start_cnt), 64'(exp_att));
        chk(irq_status == exp_irq, {tag, " irq_status"}, 64'(irq_status), 64'(exp_irq));
        chk({last_wr, last_wd} == {wr, wd}, "R2 attempt direction/data", 64'({last_wr, last_wd}), 64'({wr, wd}));
        if (clr_after != 8'h00) begin
            irq_clear = clr_after;
            @(negedge clk);
            irq_clear = 8'h00;
        end
        term_q.delete();
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
        chk(irq_status == 8'h00, "R11 reset irq", 64'(irq_status), 64'd0);
        chk(done == 1'b0 && pci_start == 1'b0, "R10 reset done/start", 64'({done, pci_start}), 64'd0);

        // R3 normal and disconnect with data
        txn(0, 32'h0, 32'hA5A5_1234, 1, 32'hA5A5_1234, 8'h00, 1, 8'h00, 0, "R3 read normal");
        term_q.push_back(3'd1);
        txn(0, 32'h0, 32'h0BAD_F00D, 1, 32'h0BAD_F00D, 8'h00, 1, 8'h00, 0, "R3 read disconnect");
        txn(1, 32'h1111_2222, 32'hDEAD_BEEF, 1, 32'h0, 8'h00, 1, 8'h00, 0, "R3 write normal");
        term_q.push_back(3'd1);
        txn(1, 32'h3333_4444, 32'hDEAD_BEEF, 1, 32'h0, 8'h00, 1, 8'h00, 0, "R3 write disconnect");

        // R4 long read retry chain
        for (int i = 0; i < 6; i++) term_q.push_back(3'd2);
        term_q.push_back(3'd0);
        txn(0, 32'h0, 32'h7777_0001, 1, 32'h7777_0001, 8'h00, 7, 8'h00, 0, "R4 read retried");

        // R5 write retry inside and past the budget
        term_q.push_back(3'd2); term_q.push_back(3'd2); term_q.push_back(3'd0);
        txn(1, 32'h5555_6666, 32'h0, 1, 32'h0, 8'h00, 3, 8'h00, 0, "R5 write retried");
        for (int i = 0; i < 10; i++) term_q.push_back(3'd2);
        txn(1, 32'h7777_8888, 32'h0, 0, ONES, 8'h20, WRR + 1, 8'hFF, 0, "R5 write retry exhausted");

        // R6 system error
        term_q.push_back(3'd5);
        txn(0, 32'h0, 32'h1234_5678, 0, ONES, 8'h01, 1, 8'h00, 0, "R6 read serr");
        term_q.push_back(3'd5);
        txn(1, 32'h9999_AAAA, 32'h0, 0, ONES, 8'h09, 1, 8'h01, 0, "R6 write serr");
        chk(irq_status == 8'h08, "R11 w1c clears only bit 0", 64'(irq_status), 64'h08);
        irq_clear = 8'hFF; @(negedge clk); irq_clear = 8'h00;

        // R7 master abort (and code 7)
        term_q.push_back(3'd3);
        txn(0, 32'h0, 32'h4242_4242, 0, ONES, 8'h00, 1, 8'h00, 0, "R7 read mabort");
        term_q.push_back(3'd3);
        txn(1, 32'hBBBB_CCCC, 32'h0, 0, ONES, 8'h10, 1, 8'hFF, 0, "R7 write mabort");
        term_q.push_back(3'd7);
        txn(1, 32'hBBBB_CCCD, 32'h0, 0, ONES, 8'h10, 1, 8'hFF, 0, "R7 write code7");

        // R8 target abort
        term_q.push_back(3'd4);
        txn(0, 32'h0, 32'h5A5A_5A5A, 0, ONES, 8'h02, 1, 8'hFF, 0, "R8 read tabort");
        term_q.push_back(3'd4);
        txn(1, 32'hDDDD_EEEE, 32'h0, 0, ONES, 8'h40, 1, 8'hFF, 0, "R8 write tabort");

        // R9 parity error
        term_q.push_back(3'd6);
        txn(0, 32'h0, 32'hC0DE_0006, 1, 32'hC0DE_0006, 8'h04, 1, 8'hFF, 0, "R9 read perr");
        term_q.push_back(3'd6);
        txn(1, 32'hFEED_0006, 32'h0, 1, 32'h0, 8'h80, 1, 8'hFF, 0, "R9 write perr");

        // R11 set wins over a clear held through completion
        term_q.push_back(3'd5);
        txn(0, 32'h0, 32'h0, 0, ONES, 8'h01, 1, 8'hFF, 1, "R11 set beats clear");
        chk(irq_status == 8'h00, "R11 cleared afterwards", 64'(irq_status), 64'h00);

        // R1 request while busy is ignored
        term_q.push_back(3'd2); term_q.push_back(3'd2); term_q.push_back(3'd0);
        rsp_data  = 32'h0102_0304;
        start_cnt = 0;
        sb_q.push_back('{1'b1, 32'h0102_0304, "R1 busy request ignored"});
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wdata = 32'h0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
        req_valid = 1'b1; req_write = 1'b1; req_wdata = 32'hFFFF_0000;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        chk(start_cnt == 3, "R1 busy attempts", 64'(start_cnt), 64'd3);
        chk(last_wr == 1'b0, "R1 busy direction kept", 64'(last_wr), 64'd0);
        repeat (8) @(negedge clk);
        chk(start_cnt == 3 && sb_q.size() == 0, "R1 no extra access", 64'(start_cnt), 64'd3);
        term_q.delete();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule